// File: doc/BRIEF.md
# Word-Packed Transmit/Receive FIFO Controller

This block sits between a processor and the byte-serial engine of a packet-mode two-wire bus master. Each direction has a queue of 32-bit words, each carrying four bytes. Software writes whole words into the transmit queue and reads whole words from the receive queue. The byte engine takes transmit bytes one at a time and delivers received bytes one at a time. The block splits words into bytes and packs bytes into words, least-significant byte first.

A transfer length, loaded when the engine starts a transfer, tells the block where the data ends. When the length is not a multiple of four, the last transmit word is only partly used: the leftover bytes are thrown away together with that word. In the same case the last receive word is written with its unused upper bytes at zero.

A control register holds two trigger levels and two flush commands that clear themselves. A status byte reports the number of free transmit slots and the number of filled receive words. Two data-request outputs compare those levels against the triggers. Two one-cycle event pulses report a write to a full transmit queue and a read from an empty receive queue.

Top module: `pkt_fifo_ctl`

## Requirements
- R1: After synchronous reset, `ctrl_rdata` reads 0x00, `status_rdata` reads 0x80 (all 8 transmit slots free, no receive words), `eng_tx_valid` and `eng_rx_ready` are low, and `tx_req` is high.
- R2: `status_rdata[7:4]` gives the free transmit word slots and `status_rdata[3:0]` gives the filled receive words. Both update in the cycle after the write, read, pop or commit that changes them.
- R3: A `tx_wr` while all transmit slots are full is dropped, and `tx_ovf` is high for exactly the one cycle after that write. The queued words and their order stay as they were.
- R4: While the receive queue is empty, `rx_rdata` reads zero. An `rx_rd` in that state raises `rx_unf` for exactly the one cycle after it.
- R5: Transmit bytes appear on `eng_tx_byte` in order: byte lane [7:0] first, then [15:8], [23:16], [31:24]. Each `eng_tx_pop` while `eng_tx_valid` is high moves to the next byte.
- R6: After `eng_tx_valid` has delivered `eng_len` bytes, it goes low until the next `eng_start`. A word of which only 1 to 3 bytes were used is removed at its last used byte. The next `eng_start` resumes at lane [7:0] of the following word.
- R7: Received bytes fill lanes starting at [7:0]. A word enters the receive queue after its fourth byte or after the last byte of the transfer length. Lanes that were not filled read zero. `eng_rx_ready` is low while the receive queue is full or the length is used up.
- R8: Writing 1 to control bit 1 (transmit) or bit 0 (receive) makes that bit read 1 for one cycle. The matching queue is empty from the cycle after. A receive flush also discards a partly packed word.
- R9: The transmit trigger is control bits [7:5] and the receive trigger is control bits [4:2]. `tx_req` is high while free transmit slots exceed the transmit trigger. `rx_req` is high while filled receive words exceed the receive trigger.
- R10: The trigger fields keep their written values while a flush executes and after it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data |
| ctrl_rdata | output | 8 | Control register readback |
| status_rdata | output | 8 | Transmit free / receive filled levels |
| tx_wr | input | 1 | Transmit word write strobe |
| tx_wdata | input | 32 | Transmit word |
| rx_rd | input | 1 | Receive word read strobe |
| rx_rdata | output | 32 | Receive queue head word, zero when empty |
| tx_req | output | 1 | Transmit data request |
| rx_req | output | 1 | Receive data request |
| tx_ovf | output | 1 | Dropped transmit write event |
| rx_unf | output | 1 | Empty receive read event |
| eng_start | input | 1 | Loads a new transfer length |
| eng_len | input | 12 | Transfer length in bytes |
| eng_tx_pop | input | 1 | Engine takes the presented transmit byte |
| eng_tx_byte | output | 8 | Presented transmit byte |
| eng_tx_valid | output | 1 | A transmit byte is available |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_rx_ready | output | 1 | A received byte can be accepted |

## Verification
The hardest case is a transfer that ends partway through a transmit word while a further word is already queued. The block must drop the rest of the partial word, stop presenting bytes, and later resume exactly at the next word's lowest lane. The stimulus queues three words and runs a six-byte transfer, which ends in the middle of the second word. It then checks that the byte stream stops and that the status shows only one slot in use. A four-byte transfer follows to confirm the restart point. A receive flush issued while one byte sits in the packing register covers the matching case on the receive side.

// File: rtl/pkt_fifo_pkg.sv
package pkt_fifo_pkg;
    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = BYTE_W * WORD_BYTES;
    localparam int LANE_W     = $clog2(WORD_BYTES);
    localparam int LVL_W      = 4;
    localparam int TRIG_W     = 3;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [LVL_W-1:0]  lvl_t;

    // control byte: trigger fields above the two flush commands
    typedef struct packed {
        logic [TRIG_W-1:0] tx_trig;   // [7:5]
        logic [TRIG_W-1:0] rx_trig;   // [4:2]
        logic              tx_flush;  // [1]
        logic              rx_flush;  // [0]
    } ctrl_t;

    typedef struct packed {
        lvl_t tx_free;                // [7:4]
        lvl_t rx_fill;                // [3:0]
    } status_t;

    function automatic byte_t lane_of(word_t w, lane_t l);
        return w[l*BYTE_W +: BYTE_W];
    endfunction

    function automatic word_t lane_place(byte_t b, lane_t l);
        return word_t'(b) << (l * BYTE_W);
    endfunction
endpackage

// File: rtl/pkt_word_fifo.sv
module pkt_word_fifo
    import pkt_fifo_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             wr,
    input  word_t            wdata,
    input  logic             rd,
    output word_t            head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    word_t            mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             wr_ok, rd_ok;

    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign wr_ok = wr && !full;
    assign rd_ok = rd && !empty;
    assign head  = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_ok) wr_ptr <= wr_ptr + PTR_W'(1);
            if (rd_ok) rd_ptr <= rd_ptr + PTR_W'(1);
            count <= count + CNT_W'(wr_ok) - CNT_W'(rd_ok);
        end
    end

    // R2: level never leaves its legal range
    assert_level_bound_R2: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R8: a flush leaves the queue empty on the next cycle
    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty);

    // R3: a write into a full queue without a read cannot change its fullness
    assert_full_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (full && wr && !rd && !flush) |=> full);
endmodule

// File: rtl/pkt_tx_unpack.sv
module pkt_tx_unpack
    import pkt_fifo_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    input  word_t            head,
    input  logic             empty,
    input  logic             pop,
    output byte_t            byte_o,
    output logic             valid,
    output logic             fifo_rd
);
    lane_t            lane;
    logic [LEN_W-1:0] remain;
    logic             last, take;

    assign valid   = !empty && (remain != '0);
    assign last    = (lane == lane_t'(WORD_BYTES - 1)) || (remain == LEN_W'(1));
    assign take    = pop && valid;
    assign fifo_rd = take && last;
    assign byte_o  = lane_of(head, lane);

    always_ff @(posedge clk) begin
        if (rst) begin
            lane   <= '0;
            remain <= '0;
        end else begin
            if (flush)     lane <= '0;
            else if (take) lane <= last ? '0 : lane + lane_t'(1);
            if (start)     remain <= len;
            else if (take) remain <= remain - LEN_W'(1);
        end
    end
endmodule

// File: rtl/pkt_rx_pack.sv
module pkt_rx_pack
    import pkt_fifo_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    input  logic             push,
    input  byte_t            byte_i,
    input  logic             full,
    output logic             ready,
    output logic             fifo_wr,
    output word_t            wdata
);
    lane_t            lane;
    logic [LEN_W-1:0] remain;
    word_t            acc;
    logic             last, take;

    assign ready   = !full && (remain != '0);
    assign last    = (lane == lane_t'(WORD_BYTES - 1)) || (remain == LEN_W'(1));
    assign take    = push && ready;
    assign fifo_wr = take && last;
    assign wdata   = acc | lane_place(byte_i, lane);

    always_ff @(posedge clk) begin
        if (rst) begin
            lane   <= '0;
            remain <= '0;
            acc    <= '0;
        end else begin
            if (flush || start) begin
                lane <= '0;
                acc  <= '0;
            end else if (take) begin
                lane <= last ? '0 : lane + lane_t'(1);
                acc  <= last ? '0 : wdata;
            end
            if (start)     remain <= len;
            else if (take) remain <= remain - LEN_W'(1);
        end
    end
endmodule

// File: rtl/pkt_fifo_ctl.sv
module pkt_fifo_ctl
    import pkt_fifo_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LEN_W = 12,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_wr,
    input  logic [7:0]       ctrl_wdata,
    output logic [7:0]       ctrl_rdata,
    output logic [7:0]       status_rdata,
    input  logic             tx_wr,
    input  logic [31:0]      tx_wdata,
    input  logic             rx_rd,
    output logic [31:0]      rx_rdata,
    output logic             tx_req,
    output logic             rx_req,
    output logic             tx_ovf,
    output logic             rx_unf,
    input  logic             eng_start,
    input  logic [LEN_W-1:0] eng_len,
    input  logic             eng_tx_pop,
    output logic [7:0]       eng_tx_byte,
    output logic             eng_tx_valid,
    input  logic             eng_rx_push,
    input  logic [7:0]       eng_rx_byte,
    output logic             eng_rx_ready
);
    ctrl_t            wr_c, ctrl_q;
    status_t          stat;
    word_t            tx_head, rx_head, rx_wdata;
    logic [CNT_W-1:0] tx_cnt, rx_cnt, tx_free;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic             tx_pop_word, rx_push_word;

    assign wr_c = ctrl_t'(ctrl_wdata);

    // flush bits live exactly one cycle; triggers hold until rewritten
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q.tx_flush <= ctrl_wr && wr_c.tx_flush;
            ctrl_q.rx_flush <= ctrl_wr && wr_c.rx_flush;
            if (ctrl_wr) begin
                ctrl_q.tx_trig <= wr_c.tx_trig;
                ctrl_q.rx_trig <= wr_c.rx_trig;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_ovf <= 1'b0;
            rx_unf <= 1'b0;
        end else begin
            tx_ovf <= tx_wr && tx_full;
            rx_unf <= rx_rd && rx_empty;
        end
    end

    pkt_word_fifo #(.DEPTH(DEPTH)) u_tx_q (
        .clk(clk), .rst(rst), .flush(ctrl_q.tx_flush),
        .wr(tx_wr), .wdata(tx_wdata), .rd(tx_pop_word),
        .head(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    pkt_word_fifo #(.DEPTH(DEPTH)) u_rx_q (
        .clk(clk), .rst(rst), .flush(ctrl_q.rx_flush),
        .wr(rx_push_word), .wdata(rx_wdata), .rd(rx_rd),
        .head(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    pkt_tx_unpack #(.LEN_W(LEN_W)) u_unpack (
        .clk(clk), .rst(rst), .flush(ctrl_q.tx_flush),
        .start(eng_start), .len(eng_len),
        .head(tx_head), .empty(tx_empty), .pop(eng_tx_pop),
        .byte_o(eng_tx_byte), .valid(eng_tx_valid), .fifo_rd(tx_pop_word)
    );

    pkt_rx_pack #(.LEN_W(LEN_W)) u_pack (
        .clk(clk), .rst(rst), .flush(ctrl_q.rx_flush),
        .start(eng_start), .len(eng_len),
        .push(eng_rx_push), .byte_i(eng_rx_byte), .full(rx_full),
        .ready(eng_rx_ready), .fifo_wr(rx_push_word), .wdata(rx_wdata)
    );

    assign tx_free      = CNT_W'(DEPTH) - tx_cnt;
    assign stat.tx_free = LVL_W'(tx_free);
    assign stat.rx_fill = LVL_W'(rx_cnt);
    assign status_rdata = stat;
    assign ctrl_rdata   = ctrl_q;
    assign rx_rdata     = rx_head;
    assign tx_req       = stat.tx_free > LVL_W'(ctrl_q.tx_trig);
    assign rx_req       = stat.rx_fill > LVL_W'(ctrl_q.rx_trig);

    // R6: a byte is only offered while at least one word is queued
    assert_tx_byte_backed_R6: assert property (@(posedge clk) disable iff (rst)
        eng_tx_valid |-> (tx_free < CNT_W'(DEPTH)));

    // R7: the engine is only told to send while a receive slot is open
    assert_rx_room_R7: assert property (@(posedge clk) disable iff (rst)
        eng_rx_ready |-> (rx_cnt < CNT_W'(DEPTH)));
endmodule

// File: tb/pkt_fifo_ctl_tb_top.sv
module pkt_fifo_ctl_tb_top;
    import pkt_fifo_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_wr = 1'b0;
    logic [7:0]  ctrl_wdata = '0;
    logic [7:0]  ctrl_rdata, status_rdata;
    logic        tx_wr = 1'b0;
    logic [31:0] tx_wdata = '0;
    logic        rx_rd = 1'b0;
    logic [31:0] rx_rdata;
    logic        tx_req, rx_req, tx_ovf, rx_unf;
    logic        eng_start = 1'b0;
    logic [11:0] eng_len = '0;
    logic        eng_tx_pop = 1'b0;
    logic [7:0]  eng_tx_byte;
    logic        eng_tx_valid;
    logic        eng_rx_push = 1'b0;
    logic [7:0]  eng_rx_byte = '0;
    logic        eng_rx_ready;

    int    nchk = 0;
    int    nerr = 0;
    bit    done = 1'b0;
    byte_t exp_q[$];

    always #4 clk = ~clk;   // 125 MHz

    pkt_fifo_ctl dut_i (
        .clk(clk), .rst(rst),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
        .status_rdata(status_rdata),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
        .tx_req(tx_req), .rx_req(rx_req), .tx_ovf(tx_ovf), .rx_unf(rx_unf),
        .eng_start(eng_start), .eng_len(eng_len),
        .eng_tx_pop(eng_tx_pop), .eng_tx_byte(eng_tx_byte), .eng_tx_valid(eng_tx_valid),
        .eng_rx_push(eng_rx_push), .eng_rx_byte(eng_rx_byte), .eng_rx_ready(eng_rx_ready)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver: writes a word and, if accepted, queues its bytes lane 0 first
    task automatic drv_tx_word(word_t w, bit accepted);
        tx_wr = 1'b1; tx_wdata = w;
        tick();
        tx_wr = 1'b0;
        if (accepted)
            for (int i = 0; i < WORD_BYTES; i++) exp_q.push_back(w[i*8 +: 8]);
    endtask

    // monitor: takes n bytes from the engine side and compares with the queue
    task automatic mon_tx_take(int n, string tag);
        for (int i = 0; i < n; i++) begin
            byte_t e;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'hxx;
            check({tag, " valid"}, 32'(eng_tx_valid), 32'd1);
            check({tag, " byte"}, 32'(eng_tx_byte), 32'(e));
            eng_tx_pop = 1'b1;
            tick();
            eng_tx_pop = 1'b0;
        end
    endtask

    task automatic eng_go(int len);
        eng_start = 1'b1; eng_len = 12'(len);
        tick();
        eng_start = 1'b0;
    endtask

    task automatic rx_put(byte_t b);
        check("R7 rx ready", 32'(eng_rx_ready), 32'd1);
        eng_rx_push = 1'b1; eng_rx_byte = b;
        tick();
        eng_rx_push = 1'b0;
    endtask

    task automatic cpu_rx_read();
        rx_rd = 1'b1;
        tick();
        rx_rd = 1'b0;
    endtask

    task automatic ctrl_write(logic [7:0] v);
        ctrl_wr = 1'b1; ctrl_wdata = v;
        tick();
        ctrl_wr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: actual expired expected completion");
        finish_run();
    end

    initial begin : stim
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        check("R1 ctrl", 32'(ctrl_rdata), 32'h00);
        check("R1 status", 32'(status_rdata), 32'h80);
        check("R1 tx valid", 32'(eng_tx_valid), 32'd0);
        check("R1 rx ready", 32'(eng_rx_ready), 32'd0);
        check("R1 tx req", 32'(tx_req), 32'd1);
        check("R1 rx req", 32'(rx_req), 32'd0);

        // R5/R6: six-byte transfer ends mid-word with a third word queued
        eng_go(6);
        drv_tx_word(32'h44332211, 1'b1);
        drv_tx_word(32'h88776655, 1'b1);
        drv_tx_word(32'hCCBBAA99, 1'b1);
        check("R2 tx free after 3 writes", 32'(status_rdata), 32'h50);
        mon_tx_take(6, "R5 tx lanes");
        check("R6 stop after length", 32'(eng_tx_valid), 32'd0);
        check("R6 partial word dropped", 32'(status_rdata), 32'h70);
        void'(exp_q.pop_front());
        void'(exp_q.pop_front());
        eng_go(4);
        mon_tx_take(4, "R6 resume next word");
        check("R6 queue drained", 32'(status_rdata), 32'h80);

        // R3: overflow
        for (int i = 0; i < 8; i++) drv_tx_word(32'h10203040 + 32'(i * 32'h01010101), 1'b1);
        check("R2 tx full", 32'(status_rdata), 32'h00);
        check("R3 no ovf before", 32'(tx_ovf), 32'd0);
        drv_tx_word(32'hDEADBEEF, 1'b0);
        check("R3 ovf pulse", 32'(tx_ovf), 32'd1);
        check("R3 still full", 32'(status_rdata), 32'h00);
        tick();
        check("R3 ovf one cycle", 32'(tx_ovf), 32'd0);
        eng_go(32);
        mon_tx_take(32, "R3 contents kept");
        check("R3 queue empty", 32'(status_rdata), 32'h80);
        check("R3 exp queue used", 32'(exp_q.size()), 32'd0);

        // R7: receive packing with a partial final word
        eng_go(6);
        for (int i = 1; i <= 4; i++) rx_put(byte_t'(i));
        check("R2 rx one word", 32'(status_rdata), 32'h81);
        rx_put(8'h05);
        rx_put(8'h06);
        check("R2 rx two words", 32'(status_rdata), 32'h82);
        check("R7 rx ready after length", 32'(eng_rx_ready), 32'd0);
        check("R7 first word", rx_rdata, 32'h04030201);
        cpu_rx_read();
        check("R7 partial word zero fill", rx_rdata, 32'h00000605);
        cpu_rx_read();
        check("R2 rx drained", 32'(status_rdata), 32'h80);

        // R4: underflow
        check("R4 empty reads zero", rx_rdata, 32'h0);
        check("R4 no unf before", 32'(rx_unf), 32'd0);
        cpu_rx_read();
        check("R4 unf pulse", 32'(rx_unf), 32'd1);
        tick();
        check("R4 unf one cycle", 32'(rx_unf), 32'd0);

        // R9: triggers tx=6 (bits 7:5) rx=1 (bits 4:2)
        ctrl_write(8'hC4);
        check("R9 ctrl readback", 32'(ctrl_rdata), 32'hC4);
        check("R9 tx req 8>6", 32'(tx_req), 32'd1);
        drv_tx_word(32'h01010101, 1'b1);
        check("R9 tx req 7>6", 32'(tx_req), 32'd1);
        drv_tx_word(32'h02020202, 1'b1);
        check("R9 tx req 6>6 low", 32'(tx_req), 32'd0);
        eng_go(8);
        for (int i = 0; i < 4; i++) rx_put(8'h30 + byte_t'(i));
        check("R9 rx req 1>1 low", 32'(rx_req), 32'd0);
        for (int i = 0; i < 4; i++) rx_put(8'h40 + byte_t'(i));
        check("R9 rx req 2>1", 32'(rx_req), 32'd1);
        check("R2 mixed levels", 32'(status_rdata), 32'h62);

        // R8/R10: flush both with a partly packed receive word pending
        eng_go(8);
        rx_put(8'hAA);
        ctrl_write(8'hC7);
        check("R8 flush bits set", 32'(ctrl_rdata), 32'hC7);
        tick();
        check("R8 flush bits cleared", 32'(ctrl_rdata), 32'hC4);
        check("R10 triggers kept", 32'(ctrl_rdata[7:2]), 32'h31);
        check("R8 queues empty", 32'(status_rdata), 32'h80);
        check("R8 tx valid after flush", 32'(eng_tx_valid), 32'd0);
        exp_q.delete();
        for (int i = 1; i <= 4; i++) rx_put(byte_t'(i));
        check("R8 pack restarts lane 0", rx_rdata, 32'h04030201);

        finish_run();
    end
endmodule